// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two pieces of information: the branch's own address and the directions of the last two branches the core resolved, whichever branches those were. The address selects one row of a pattern table. Each row holds one small saturating counter for every possible global history value. The current global history picks one counter in the row, and the top bit of that counter is the guess. This lets one branch learn a different direction for each recent-path context, so pairs of branches whose directions depend on each other are predicted correctly after a short warm-up.

The fetch side presents a PC and receives the guessed direction in the same cycle. It also receives the history value that was used, and it keeps that value with the branch. When the branch resolves, the execute side returns the PC, that saved history value and the real outcome. At the next clock edge the block moves only the selected counter one step toward the outcome. In the same edge it shifts the outcome into the global history register.

Top module: `gcorr_bpred`

## Requirements
- R1: After reset the global history reads 0 (both recent outcomes not-taken). Every counter holds the reset level CTR_INIT, which is 1 by default (weakly not-taken), so every PC is predicted not-taken.
- R2: `pred_taken_o` is the most significant bit of the counter at row `pred_pc[IDX_LSB +: log2(ENTRIES)]` and slot `pred_hist_o`. It is combinational and reflects the table as of the last clock edge. `pred_hist_o` is the current global history.
- R3: Counters are unsigned, from 0 (strongly not-taken) to 2^CTR_W-1 (strongly taken). A taken resolve raises the selected counter by one and stops at the maximum. A not-taken resolve lowers it by one and stops at 0.
- R4: A resolve changes exactly one counter. The slots of the same row that were not selected, and all other rows, keep their values.
- R5: On each clock edge with `res_valid`=1 the history becomes `{old_history[HIST_W-2:0], res_taken}`, so bit 0 is the newest outcome. Without `res_valid` the history holds.
- R6: A resolve picks its slot from the supplied `res_hist`, not from the current global history.
- R7: Rows are chosen only by `pc[IDX_LSB +: log2(ENTRIES)]`. PCs that differ only in other bits share one row.
- R8: Take two correlated branches whose directions alternate as taken,taken,not-taken,not-taken, and so on. Starting from reset, only the first two predictions are wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | Global history used for this prediction, to be returned on resolve |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_hist | input | HIST_W | History value captured when that branch was predicted |
| res_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench builds the block with ENTRIES=16 and keeps the default IDX_LSB=2, HIST_W=2, CTR_W=2 and CTR_INIT=1. A table this small lets random PCs hit every row and every slot many times, so writes to one counter that leak into a neighbour show up quickly. PCs that differ above bit 5 alias onto the same row, which exercises the index slicing directly. The default counter width keeps saturation at both ends within a few directed resolves, and the two-bit history lets the alternating correlated pair run exactly as specified.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

  // One saturating step of an unsigned counter in [0, top].
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input int unsigned top,
                                           input logic        up);
    if (up) return (cur >= top) ? top : cur + 1;
    else    return (cur == 0)   ? 0   : cur - 1;
  endfunction

endpackage

// File: rtl/gcb_index.sv
module gcb_index #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 1024,
  parameter int IDX_LSB = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[IDX_LSB +: IDX_W];
endmodule

// File: rtl/gcb_ghr.sv
module gcb_ghr #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = bit_in;
    end else begin : g_multi
      assign hist_d = {hist_q[HIST_W-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gcb_pht.sv
module gcb_pht #(
  parameter int ENTRIES  = 1024,
  parameter int HIST_W   = 2,
  parameter int CTR_W    = 2,
  parameter int CTR_INIT = 1,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int SLOTS   = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [HIST_W-1:0] rd_slot,
  output logic [CTR_W-1:0]  rd_ctr_o,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HIST_W-1:0] wr_slot,
  input  logic              wr_taken,
  output logic [CTR_W-1:0]  wr_old_o,
  output logic [CTR_W-1:0]  wr_new_o,
  output logic [SLOTS-1:0]  slot_we_o
);
  import gcb_pkg::*;

  localparam int unsigned CTR_MAX = (1 << CTR_W) - 1;

  logic [CTR_W-1:0] rd_all [SLOTS];
  logic [CTR_W-1:0] wr_all [SLOTS];
  logic [CTR_W-1:0] wr_new;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [CTR_W-1:0] mem [ENTRIES];

      assign slot_we_o[s] = wr_en && (wr_slot == HIST_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int e = 0; e < ENTRIES; e++) mem[e] <= CTR_W'(CTR_INIT);
        end else if (slot_we_o[s]) begin
          mem[wr_idx] <= wr_new;
        end
      end

      assign rd_all[s] = mem[rd_idx];
      assign wr_all[s] = mem[wr_idx];
    end
  endgenerate

  assign rd_ctr_o = rd_all[rd_slot];
  assign wr_old_o = wr_all[wr_slot];
  assign wr_new   = CTR_W'(sat_step(32'(wr_old_o), CTR_MAX, wr_taken));
  assign wr_new_o = wr_new;
endmodule

// File: rtl/gcorr_bpred.sv
module gcorr_bpred #(
  parameter int PC_W     = 32,
  parameter int ENTRIES  = 1024,
  parameter int HIST_W   = 2,
  parameter int CTR_W    = 2,
  parameter int CTR_INIT = 1,
  parameter int IDX_LSB  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              res_valid,
  input  logic [PC_W-1:0]   res_pc,
  input  logic [HIST_W-1:0] res_hist,
  input  logic              res_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SLOTS = 1 << HIST_W;

  logic [IDX_W-1:0]  pred_idx, res_idx;
  logic [HIST_W-1:0] ghr;
  logic [CTR_W-1:0]  pred_ctr;
  // Internal events brought out for the checker
  logic [CTR_W-1:0]  res_ctr_old, res_ctr_new;
  logic [SLOTS-1:0]  res_slot_we;

  gcb_index #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)) u_pidx (
    .pc(pred_pc), .idx(pred_idx));

  gcb_index #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)) u_ridx (
    .pc(res_pc), .idx(res_idx));

  gcb_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst_n(rst_n), .shift_en(res_valid), .bit_in(res_taken),
    .hist_o(ghr));

  gcb_pht #(.ENTRIES(ENTRIES), .HIST_W(HIST_W), .CTR_W(CTR_W),
            .CTR_INIT(CTR_INIT)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_idx), .rd_slot(ghr), .rd_ctr_o(pred_ctr),
    .wr_en(res_valid), .wr_idx(res_idx), .wr_slot(res_hist),
    .wr_taken(res_taken), .wr_old_o(res_ctr_old), .wr_new_o(res_ctr_new),
    .slot_we_o(res_slot_we));

  assign pred_taken_o = pred_ctr[CTR_W-1];
  assign pred_hist_o  = ghr;
endmodule

module gcorr_bpred_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  localparam int SLOTS = 1 << HIST_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken_o,
  input logic [HIST_W-1:0] pred_hist_o,
  input logic              res_valid,
  input logic              res_taken,
  input logic [CTR_W-1:0]  res_ctr_old,
  input logic [CTR_W-1:0]  res_ctr_new,
  input logic [SLOTS-1:0]  res_slot_we
);
  p_hist_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pred_hist_o == '0);

  p_pred_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid ##1 $stable(pred_pc) |-> $stable(pred_taken_o));

  p_up_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_taken |-> res_ctr_new >= res_ctr_old);

  p_down_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_taken |-> res_ctr_new <= res_ctr_old);

  p_one_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(res_slot_we) == 1);

  p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> res_slot_we == '0);

  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> pred_hist_o[0] == $past(res_taken));

  p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(pred_hist_o));
endmodule

bind gcorr_bpred gcorr_bpred_chk #(.PC_W(PC_W), .HIST_W(HIST_W), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken_o(pred_taken_o),
  .pred_hist_o(pred_hist_o), .res_valid(res_valid), .res_taken(res_taken),
  .res_ctr_old(res_ctr_old), .res_ctr_new(res_ctr_new),
  .res_slot_we(res_slot_we));

// File: tb/gcorr_bpred_tb.sv
module gcorr_bpred_tb;
  localparam int ROWS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken_o;
  logic [1:0]  pred_hist_o;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic [1:0]  res_hist = '0;
  logic        res_taken = 1'b0;

  int unsigned tests = 0, fails = 0;
  int unsigned mdl [ROWS][4];
  int unsigned mhist;

  always #5 clk = ~clk;

  gcorr_bpred #(.PC_W(32), .ENTRIES(ROWS), .HIST_W(2), .CTR_W(2),
                .CTR_INIT(1), .IDX_LSB(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken_o(pred_taken_o),
    .pred_hist_o(pred_hist_o), .res_valid(res_valid), .res_pc(res_pc),
    .res_hist(res_hist), .res_taken(res_taken));

  function automatic int unsigned row_of(input logic [31:0] pc);
    return (pc / 4) % ROWS;
  endfunction

  function automatic int unsigned bump(input int unsigned c, input logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < 4; s++) mdl[r][s] = 1;
    mhist = 0;
  endtask

  // One cycle: drive at negedge, check the prediction, model the edge.
  task automatic cyc(input logic [31:0] ppc, input logic rv, input logic [31:0] rpc,
                     input logic [1:0] rh, input logic rt, input string tag,
                     input logic chk, output logic got_t, output logic [1:0] got_h);
    @(negedge clk);
    pred_pc = ppc; res_valid = rv; res_pc = rpc; res_hist = rh; res_taken = rt;
    #1;
    got_t = pred_taken_o; got_h = pred_hist_o;
    if (chk) begin
      check({tag, " dir"}, 32'(pred_taken_o), (mdl[row_of(ppc)][mhist] >= 2) ? 1 : 0);
      check({tag, " hist"}, 32'(pred_hist_o), mhist);
    end
    @(posedge clk); #1;
    if (rv) begin
      mdl[row_of(rpc)][rh] = bump(mdl[row_of(rpc)][rh], rt);
      mhist = ((mhist * 2) % 4) + (rt ? 1 : 0);
    end
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [1:0] h, input logic t);
    logic gt; logic [1:0] gh;
    cyc(32'h0, 1'b1, pc, h, t, "", 1'b0, gt, gh);
  endtask

  task automatic peek(input logic [31:0] pc, input string tag);
    logic gt; logic [1:0] gh;
    cyc(pc, 1'b0, 32'h0, 2'd0, 1'b0, tag, 1'b1, gt, gh);
  endtask

  // Steer the history to v using a scratch row (row 15).
  task automatic steer(input logic [1:0] v);
    resolve(32'h3C, 2'd3, v[1]);
    resolve(32'h3C, 2'd3, v[0]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; res_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  task automatic run();
    logic gt; logic [1:0] gh;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: all rows predict not-taken, history zero
    for (int r = 0; r < ROWS; r++) begin
      cyc(32'(r * 4), 1'b0, 32'h0, 2'd0, 1'b0, "R1", 1'b0, gt, gh);
      check("R1 reset dir", 32'(gt), 0);
    end
    check("R1 reset hist", 32'(gh), 0);

    // R3: saturate upward on row 0 slot 0, then downward
    for (int k = 0; k < 4; k++) resolve(32'h40, 2'd0, 1'b1);
    steer(2'd0);
    peek(32'h40, "R3 top");
    resolve(32'h40, 2'd0, 1'b0);          // 3 -> 2, still taken
    steer(2'd0);
    peek(32'h40, "R3 after one down");
    for (int k = 0; k < 5; k++) resolve(32'h40, 2'd0, 1'b0);
    resolve(32'h40, 2'd0, 1'b1);          // 0 -> 1, not taken
    steer(2'd0);
    peek(32'h40, "R3 bottom");
    check("R3 bottom model", mdl[0][0], 1);

    // R6/R4: write row 5 slot 2 while history differs, read per slot
    steer(2'd1);
    resolve(32'h14, 2'd2, 1'b1);
    resolve(32'h14, 2'd2, 1'b1);
    steer(2'd2);
    cyc(32'h14, 1'b0, 32'h0, 2'd0, 1'b0, "R6", 1'b1, gt, gh);
    check("R6 supplied slot trained", 32'(gt), 1);
    steer(2'd0);
    cyc(32'h14, 1'b0, 32'h0, 2'd0, 1'b0, "R4", 1'b1, gt, gh);
    check("R4 other slot untouched", 32'(gt), 0);
    steer(2'd3);
    cyc(32'h18, 1'b0, 32'h0, 2'd0, 1'b0, "R4 row", 1'b1, gt, gh);
    check("R4 other row untouched", 32'(gt), 0);

    // R7: aliasing through upper and lower PC bits
    steer(2'd2);
    cyc(32'h0000_0054, 1'b0, 32'h0, 2'd0, 1'b0, "R7 alias hi", 1'b1, gt, gh);
    check("R7 alias upper bits", 32'(gt), 1);
    cyc(32'hFFFF_FF17, 1'b0, 32'h0, 2'd0, 1'b0, "R7 alias lo", 1'b1, gt, gh);
    check("R7 alias low bits", 32'(gt), 1);

    // R5: history hold and shift
    cyc(32'h0, 1'b0, 32'h0, 2'd0, 1'b0, "R5 hold", 1'b1, gt, gh);
    resolve(32'h0, 2'd0, 1'b1);
    cyc(32'h0, 1'b0, 32'h0, 2'd0, 1'b0, "R5 shift", 1'b1, gt, gh);
    check("R5 shifted value", 32'(gh), 32'd1);

    // R8: correlated alternating pair from reset
    do_reset();
    begin
      int unsigned miss = 0;
      for (int n = 0; n < 16; n++) begin
        logic [31:0] pc;
        logic outc;
        pc = n[0] ? 32'h208 : 32'h200;
        outc = ((n / 2) % 2 == 0);
        cyc(pc, 1'b0, 32'h0, 2'd0, 1'b0, "R8", 1'b1, gt, gh);
        check($sformatf("R8 mispredict at %0d", n), 32'(gt != outc), (n < 2) ? 1 : 0);
        if (gt != outc) miss++;
        cyc(32'h0, 1'b1, pc, gh, outc, "", 1'b0, gt, gh);
      end
      check("R8 total mispredicts", miss, 2);
    end

    // R2/R4/R5/R6: constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ppc, rpc;
      logic rv, rt;
      logic [1:0] rh;
      ppc = {$urandom_range(0, 255), 2'b00} ^ ($urandom_range(0, 1) ? 32'h8000_0000 : 32'h0);
      rpc = {$urandom_range(0, 63), 2'b00};
      rv  = ($urandom_range(0, 9) < 6);
      rh  = 2'($urandom_range(0, 3));
      rt  = ($urandom_range(0, 9) < 7);
      cyc(ppc, rv, rpc, rh, rt, "R2 random", 1'b1, gt, gh);
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule